// File: doc/BRIEF.md
# SPI Master with Word-Level Peripheral Selection

This block is a serial peripheral interface master. Each write to its transmit register queues one character. The character is shifted out on MOSI while MISO is shifted in. The received character is then latched and flagged. A small register set holds an enable bit, a mode word and one configuration entry per chip-select line. Each entry holds a character length of 8 to 16 bits and a keep-selected option.

Two ways of picking the target peripheral are offered. In fixed selection the chip-select code comes from the mode word, and only rewriting that word changes the target. In per-word selection every 32-bit transmit word carries its own chip-select code and an end-of-transfer flag next to the data. A stream of words can therefore reach several peripherals, and can end a framed burst, with no register rewrites in between. The four select lines either drive one line at a time, or carry the raw 4-bit code for an external decoder.

Top module: `spi_psel_master`

Register addresses (`wrAddr`):
- Address 0 is control. Bit 0 enables; bit 1 disables, and wins when both bits are set.
- Address 1 is the mode word. Bit 0 selects per-word selection, bit 1 selects decoder output, bits 7:4 hold the fixed code and bits 15:8 hold the half-period H.
- Address 2 is the transmit word.
- Addresses 4 to 7 are the entries for lines 0 to 3. Bits 3:0 hold the extra length L, and bit 4 holds the keep-selected option.

## Requirements
- R1: After reset, `csN` is 4'b1111, `sclk` is low, `tdre` is 1, `rdrf` is 0 and `txEmpty` is 1.
- R2: In fixed selection (mode bit 0 = 0), the select code is mode bits 7:4. Only the transmit data in bits 15:0 is used, and the code and flag fields of the word have no effect.
- R3: In per-word selection (mode bit 0 = 1), the transmit word supplies data in bits 15:0, the select code in bits 19:16 and the end-of-transfer flag in bit 24. All other bits are ignored.
- R4: The character length is 8 + min(L, 8) bits, where L is taken from the entry of the addressed line. The low n bits of the data are sent on MOSI, most significant bit first.
- R5: MISO is sampled on each rising SCLK edge. The received character appears on `rxData` zero-extended to 16 bits, and `rdrf` rises with it.
- R6: If the entry's keep bit (bit 4) is 0, `csN` returns to 4'b1111 after the character. If the keep bit is 1 and the flag is clear, the line stays asserted.
- R7: If the end-of-transfer flag is set, the line is released after that character even when keep is set.
- R8: With decoder output enabled (mode bit 1 = 1), `csN` carries the 4-bit code directly during a character, and the entry index is code bits 1:0.
- R9: Without decoder output, the lowest zero bit of the code selects the line, which is driven low alone. Code 4'b1111 selects no line and uses entry 0.
- R10: The SCLK period is 2·H system clocks, with H = 0 acting as 1. SCLK idles low, which is SPI mode 0.
- R11: `tdre` falls on a transmit write and rises one cycle later, when the word enters the shifter. `txEmpty` is 1 only when both the holding register and the shifter are empty.
- R12: A disable command releases `csN` to 4'b1111 and blocks new characters, while the mode word and the entries are kept. A later enable resumes with the queued word.
- R13: A pulse on `rdAck` clears `rdrf`. If a character completes in the same cycle, `rdrf` stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register address |
| wrData | input | 32 | Register write data |
| rdAck | input | 1 | Clears the receive-ready flag |
| miso | input | 1 | Serial data from the peripheral |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the peripheral |
| csN | output | 4 | Chip-select lines, active low |
| rxData | output | 16 | Last received character, zero-extended |
| tdre | output | 1 | Transmit holding register empty |
| rdrf | output | 1 | Received character ready |
| txEmpty | output | 1 | Holding register and shifter both empty |

## Verification
The completion of a character can fall in the same cycle as a software acknowledge of the previous one. Completion sets `rdrf` and the acknowledge clears it. The bench provokes the overlap by holding `rdAck` high through a whole character and dropping it right after `txEmpty` rises. The check passes only if `rdrf` is still high afterwards, which means the new data was not lost. A second overlap occurs when a disable arrives while a kept line is still asserted, and the bench judges it by the select lines and by the next character's length.

// File: rtl/spi_psel_pkg.sv
package spi_psel_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_MODE = 3'd1;
  localparam logic [ADDR_W-1:0] A_TX   = 3'd2;
  localparam int ENTRY_BASE = 4;

  // transmit word field positions
  localparam int F_CODE_LO = 16;
  localparam int F_LAST    = 24;
  // mode word field positions
  localparam int M_VAR     = 0;
  localparam int M_DEC     = 1;
  localparam int M_CODE_LO = 4;
  localparam int M_DIV_LO  = 8;
  // entry field positions
  localparam int E_KEEP    = 4;
  // control bits
  localparam int C_EN      = 0;
  localparam int C_DIS     = 1;

  typedef struct packed {
    logic load;
    logic sample;
    logic shift;
    logic finish;
    logic abort;
  } strobe_t;
endpackage

// File: rtl/spi_psel_regs.sv
module spi_psel_regs
  import spi_psel_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int MIN_BITS = 8,
  parameter int NUM_CS   = 4,
  parameter int DIV_W    = 8,
  parameter int WORD_W   = 32,
  localparam int LEN_W   = $clog2(DATA_W + 1),
  localparam int IDX_W   = $clog2(NUM_CS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [WORD_W-1:0] wrData,
  input  logic              load,
  output logic              enabled,
  output logic              holdValid,
  output logic [DIV_W-1:0]  halfDiv,
  output logic [DATA_W-1:0] txData,
  output logic [NUM_CS-1:0] csPat,
  output logic [LEN_W-1:0]  nBits,
  output logic              relAfter,
  output logic              decodeMode,
  output logic              disStrobe
);
  localparam int EXTRA_MAX = DATA_W - MIN_BITS;
  localparam int EXT_W     = $clog2(EXTRA_MAX + 1);

  logic              modeVar, modeDec;
  logic [NUM_CS-1:0] modeCode;
  logic [DIV_W-1:0]  divReg;
  logic [DATA_W-1:0] holdData;
  logic [NUM_CS-1:0] holdCode;
  logic              holdLast;
  logic [EXT_W-1:0]  entryLen [NUM_CS];
  logic              entryKeep [NUM_CS];

  logic wrCtrl, wrMode, wrTx;
  assign wrCtrl = wrEn && (wrAddr == A_CTRL);
  assign wrMode = wrEn && (wrAddr == A_MODE);
  assign wrTx   = wrEn && (wrAddr == A_TX);
  assign disStrobe = wrCtrl && wrData[C_DIS];

  logic unusedWord;
  assign unusedWord = ^{wrData[WORD_W-1:F_LAST+1], wrData[F_LAST-1:F_CODE_LO+NUM_CS]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enabled  <= 1'b0;
      modeVar  <= 1'b0;
      modeDec  <= 1'b0;
      modeCode <= '1;
      divReg   <= '0;
    end else begin
      if (wrCtrl) begin
        if (wrData[C_DIS])     enabled <= 1'b0;
        else if (wrData[C_EN]) enabled <= 1'b1;
      end
      if (wrMode) begin
        modeVar  <= wrData[M_VAR];
        modeDec  <= wrData[M_DEC];
        modeCode <= wrData[M_CODE_LO +: NUM_CS];
        divReg   <= wrData[M_DIV_LO +: DIV_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdValid <= 1'b0;
      holdData  <= '0;
      holdCode  <= '1;
      holdLast  <= 1'b0;
    end else if (wrTx) begin
      holdValid <= 1'b1;
      holdData  <= wrData[DATA_W-1:0];
      holdCode  <= wrData[F_CODE_LO +: NUM_CS];
      holdLast  <= wrData[F_LAST];
    end else if (load) begin
      holdValid <= 1'b0;
    end
  end

  for (genvar g = 0; g < NUM_CS; g++) begin : gEntry
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        entryLen[g]  <= '0;
        entryKeep[g] <= 1'b0;
      end else if (wrEn && (wrAddr == ADDR_W'(ENTRY_BASE + g))) begin
        entryLen[g]  <= wrData[EXT_W-1:0];
        entryKeep[g] <= wrData[E_KEEP];
      end
    end
  end

  // selection decode for the queued word
  logic [NUM_CS-1:0] code;
  logic              found;
  logic [IDX_W-1:0]  lowIdx, entIdx;
  logic [EXT_W-1:0]  lenSel, extra;

  always_comb begin
    code  = modeVar ? holdCode : modeCode;
    found = 1'b0;
    lowIdx = '0;
    for (int i = NUM_CS - 1; i >= 0; i--) begin
      if (!code[i]) begin
        found  = 1'b1;
        lowIdx = IDX_W'(i);
      end
    end
    if (modeDec) begin
      entIdx = code[IDX_W-1:0];
      csPat  = code;
    end else begin
      entIdx = found ? lowIdx : '0;
      csPat  = found ? ~(NUM_CS'(1) << lowIdx) : '1;
    end
    lenSel   = entryLen[entIdx];
    extra    = (lenSel > EXT_W'(EXTRA_MAX)) ? EXT_W'(EXTRA_MAX) : lenSel;
    nBits    = LEN_W'(MIN_BITS) + LEN_W'(extra);
    relAfter = !entryKeep[entIdx] || (modeVar && holdLast);
  end

  assign txData     = holdData;
  assign decodeMode = modeDec;
  assign halfDiv    = (divReg == '0) ? DIV_W'(1) : divReg;

  p_tdre_load_r11: assert property (@(posedge clk) disable iff (!rstN)
    (load && !wrTx) |=> !holdValid);
  p_write_holds_r11: assert property (@(posedge clk) disable iff (!rstN)
    wrTx |=> holdValid);
endmodule

// File: rtl/spi_psel_ctrl.sv
module spi_psel_ctrl
  import spi_psel_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DIV_W  = 8,
  localparam int LEN_W = $clog2(DATA_W + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enabled,
  input  logic             holdValid,
  input  logic [DIV_W-1:0] halfDiv,
  input  logic [LEN_W-1:0] nBits,
  input  logic             abortReq,
  output strobe_t          st,
  output logic             sclk,
  output logic             busy
);
  typedef enum logic { S_IDLE, S_SHIFT } state_t;
  state_t state;
  logic [DIV_W-1:0] divCnt;
  logic [LEN_W-1:0] bitCnt;
  logic tick;

  assign busy = (state == S_SHIFT);
  assign tick = busy && (divCnt == halfDiv - DIV_W'(1));

  always_comb begin
    st.abort  = abortReq;
    st.load   = !busy && enabled && holdValid && !abortReq;
    st.sample = tick && !sclk && !abortReq;
    st.shift  = tick && sclk && (bitCnt != LEN_W'(1)) && !abortReq;
    st.finish = tick && sclk && (bitCnt == LEN_W'(1)) && !abortReq;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      divCnt <= '0;
      bitCnt <= '0;
      sclk   <= 1'b0;
    end else if (abortReq) begin
      state <= S_IDLE;
      sclk  <= 1'b0;
    end else if (st.load) begin
      state  <= S_SHIFT;
      divCnt <= '0;
      bitCnt <= nBits;
      sclk   <= 1'b0;
    end else if (busy) begin
      if (tick) begin
        divCnt <= '0;
        sclk   <= !sclk;
        if (sclk) begin
          if (bitCnt == LEN_W'(1)) state <= S_IDLE;
          else                     bitCnt <= bitCnt - LEN_W'(1);
        end
      end else begin
        divCnt <= divCnt + DIV_W'(1);
      end
    end
  end

  p_len_range_r4: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (bitCnt >= LEN_W'(1) && bitCnt <= LEN_W'(DATA_W)));
  p_sclk_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !sclk);
  p_finish_low_r10: assert property (@(posedge clk) disable iff (!rstN)
    st.finish |=> (!sclk && !busy));
endmodule

// File: rtl/spi_psel_dp.sv
module spi_psel_dp
  import spi_psel_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int NUM_CS = 4,
  localparam int LEN_W = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           st,
  input  logic [DATA_W-1:0] txData,
  input  logic [NUM_CS-1:0] csPat,
  input  logic [LEN_W-1:0]  nBits,
  input  logic              relAfter,
  input  logic              decodeMode,
  input  logic              miso,
  input  logic              rdAck,
  output logic              mosi,
  output logic [NUM_CS-1:0] csN,
  output logic [DATA_W-1:0] rxData,
  output logic              rdrf
);
  logic [DATA_W-1:0] txSh, rxSh;
  logic              relHeld;
  logic [LEN_W-1:0]  padBits;

  assign padBits = LEN_W'(DATA_W) - nBits;
  assign mosi    = txSh[DATA_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSh    <= '0;
      rxSh    <= '0;
      relHeld <= 1'b1;
    end else if (st.load) begin
      txSh    <= txData << padBits;
      rxSh    <= '0;
      relHeld <= relAfter;
    end else begin
      if (st.shift)  txSh <= txSh << 1;
      if (st.sample) rxSh <= {rxSh[DATA_W-2:0], miso};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData <= '0;
      rdrf   <= 1'b0;
    end else if (st.finish) begin
      rxData <= rxSh;
      rdrf   <= 1'b1;
    end else if (rdAck) begin
      rdrf   <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      csN <= '1;
    else if (st.abort)              csN <= '1;
    else if (st.load)               csN <= csPat;
    else if (st.finish && relHeld)  csN <= '1;
  end

  p_rdrf_set_r13: assert property (@(posedge clk) disable iff (!rstN)
    st.finish |=> rdrf);
  p_release_r7: assert property (@(posedge clk) disable iff (!rstN)
    (st.finish && relHeld) |=> (csN == '1));
  p_one_line_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!decodeMode && st.load) |=> $onehot0(~csN));
  p_abort_r12: assert property (@(posedge clk) disable iff (!rstN)
    st.abort |=> (csN == '1));
endmodule

// File: rtl/spi_psel_master.sv
module spi_psel_master
  import spi_psel_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int MIN_BITS = 8,
  parameter int NUM_CS   = 4,
  parameter int DIV_W    = 8,
  parameter int WORD_W   = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [WORD_W-1:0] wrData,
  input  logic              rdAck,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic [NUM_CS-1:0] csN,
  output logic [DATA_W-1:0] rxData,
  output logic              tdre,
  output logic              rdrf,
  output logic              txEmpty
);
  localparam int LEN_W = $clog2(DATA_W + 1);

  strobe_t           st;
  logic              enabled, holdValid, relAfter, decodeMode, disStrobe, busy;
  logic [DIV_W-1:0]  halfDiv;
  logic [DATA_W-1:0] txData;
  logic [NUM_CS-1:0] csPat;
  logic [LEN_W-1:0]  nBits;

  spi_psel_regs #(.DATA_W(DATA_W), .MIN_BITS(MIN_BITS), .NUM_CS(NUM_CS),
                  .DIV_W(DIV_W), .WORD_W(WORD_W)) uRegs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .load(st.load), .enabled(enabled), .holdValid(holdValid), .halfDiv(halfDiv),
    .txData(txData), .csPat(csPat), .nBits(nBits), .relAfter(relAfter),
    .decodeMode(decodeMode), .disStrobe(disStrobe)
  );

  spi_psel_ctrl #(.DATA_W(DATA_W), .DIV_W(DIV_W)) uCtrl (
    .clk(clk), .rstN(rstN), .enabled(enabled), .holdValid(holdValid),
    .halfDiv(halfDiv), .nBits(nBits), .abortReq(disStrobe),
    .st(st), .sclk(sclk), .busy(busy)
  );

  spi_psel_dp #(.DATA_W(DATA_W), .NUM_CS(NUM_CS)) uDp (
    .clk(clk), .rstN(rstN), .st(st), .txData(txData), .csPat(csPat),
    .nBits(nBits), .relAfter(relAfter), .decodeMode(decodeMode),
    .miso(miso), .rdAck(rdAck), .mosi(mosi), .csN(csN),
    .rxData(rxData), .rdrf(rdrf)
  );

  assign tdre    = !holdValid;
  assign txEmpty = !holdValid && !busy;

  p_load_busy_r11: assert property (@(posedge clk) disable iff (!rstN)
    st.load |=> !txEmpty);
endmodule

// File: tb/spi_psel_master_test.sv
`timescale 1ns/1ps
module spi_psel_master_test;
  logic        clk = 0, rstN = 0, wrEn = 0, rdAck = 0, miso = 0;
  logic [2:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic        sclk, mosi, tdre, rdrf, txEmpty;
  logic [3:0]  csN;
  logic [15:0] rxData;

  int checks = 0, errors = 0;
  logic [15:0] capMosi, replyVec;
  int          capCnt, replyIdx;
  logic [3:0]  csSeen;

  always #5 clk = ~clk;

  spi_psel_master uut (.clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAck(rdAck), .miso(miso), .sclk(sclk), .mosi(mosi),
    .csN(csN), .rxData(rxData), .tdre(tdre), .rdrf(rdrf), .txEmpty(txEmpty));

  // peripheral model, mode 0
  always @(posedge sclk) begin
    capMosi = {capMosi[14:0], mosi};
    capCnt++;
    csSeen = csN;
  end
  always @(negedge sclk) begin
    if (replyIdx > 0) begin
      replyIdx--;
      miso = replyVec[replyIdx];
    end
  end

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 0;
  endtask

  function automatic logic [31:0] vw(input bit last, input logic [3:0] code, input logic [15:0] data);
    return {7'h0, last, 4'h0, code, data};
  endfunction

  task automatic prep(input int n, input logic [15:0] reply);
    capMosi = 0; capCnt = 0; replyVec = reply;
    replyIdx = n - 1; miso = reply[n-1];
  endtask

  task automatic xfer(input logic [31:0] word, input int n, input logic [15:0] reply,
                      input logic [15:0] expData, input logic [3:0] expCs, input string req);
    logic [15:0] mask;
    mask = 16'((32'h1 << n) - 1);
    prep(n, reply);
    wr(3'd2, word);
    wait (txEmpty == 1'b1);
    @(negedge clk);
    chk(capCnt == n, {req, " R4 bit count"}, capCnt, n);
    chk(capMosi == expData, {req, " R4 mosi data"}, capMosi, expData);
    chk(csSeen == expCs, {req, " select lines"}, csSeen, expCs);
    chk(rxData == (reply & mask) && rdrf, {req, " R5 received"}, {rdrf, rxData}, {1'b1, reply & mask});
    @(negedge clk); rdAck = 1;
    @(negedge clk); rdAck = 0;
    chk(!rdrf, "R13 ack clears", rdrf, 0);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk(csN == 4'hF && !sclk, "R1 idle lines", {sclk, csN}, 5'h0F);
    chk(tdre && !rdrf && txEmpty, "R1 flags", {tdre, rdrf, txEmpty}, 3'b101);
  endtask

  task automatic t_fixed;
    wr(3'd1, 32'h0000_00D0);  // fixed, code 1101 (line1, 16 bit)
    xfer(32'h01FE_1234, 16, 16'hC3A5, 16'h1234, 4'b1101, "R2 fixed");
    chk(csN == 4'hF, "R6 release no keep", csN, 4'hF);
  endtask

  task automatic t_tdre;
    wr(3'd1, 32'h0000_02D0);
    chk(tdre && txEmpty, "R11 before", {tdre, txEmpty}, 2'b11);
    prep(16, 16'h0F0F);
    wr(3'd2, vw(0, 4'h0, 16'h8001));
    chk(!tdre && !txEmpty, "R11 after write", {tdre, txEmpty}, 2'b00);
    @(negedge clk);
    chk(tdre && !txEmpty, "R11 after load", {tdre, txEmpty}, 2'b10);
    wait (txEmpty == 1'b1);
    @(negedge clk);
    chk(capMosi == 16'h8001 && rxData == 16'h0F0F, "R10 divided char", {capMosi, rxData}, {16'h8001, 16'h0F0F});
    @(negedge clk); rdAck = 1; @(negedge clk); rdAck = 0;
  endtask

  task automatic t_variable;
    wr(3'd1, 32'h0000_0001);
    xfer({7'h55, 1'b0, 4'hA, 4'b1101, 16'hBEEF}, 16, 16'h1357, 16'hBEEF, 4'b1101, "R3 var line1");
    xfer(vw(0, 4'b0111, 16'hFFFF), 10, 16'h02AA, 16'h03FF, 4'b0111, "R9 var line3");
  endtask

  task automatic t_keep;
    xfer(vw(0, 4'b1011, 16'hFABC), 12, 16'h0ABC, 16'h0ABC, 4'b1011, "R6 keep");
    chk(csN == 4'b1011, "R6 held after char", csN, 4'b1011);
    xfer(vw(1, 4'b1011, 16'h0555), 12, 16'h0123, 16'h0555, 4'b1011, "R7 last");
    chk(csN == 4'hF, "R7 released", csN, 4'hF);
  endtask

  task automatic t_nodecode;
    xfer(vw(0, 4'b1111, 16'h005A), 8, 16'h00A5, 16'h005A, 4'b1111, "R9 no line");
    xfer(vw(0, 4'b0110, 16'h00C3), 8, 16'h0011, 16'h00C3, 4'b1110, "R9 lowest zero");
  endtask

  task automatic t_decode_disable;
    wr(3'd1, 32'h0000_0103);
    xfer(vw(0, 4'b0110, 16'h0123), 12, 16'h0321, 16'h0123, 4'b0110, "R8 decode");
    chk(csN == 4'b0110, "R8 code held", csN, 4'b0110);
    wr(3'd0, 32'h2);
    chk(csN == 4'hF, "R12 disable release", csN, 4'hF);
    prep(12, 16'h0777);
    wr(3'd2, vw(1, 4'b0110, 16'h0456));
    repeat (20) @(negedge clk);
    chk(csN == 4'hF && !sclk && !tdre && capCnt == 0, "R12 blocked",
        {csN, sclk, tdre, 8'(capCnt)}, {4'hF, 1'b0, 1'b0, 8'h0});
    wr(3'd0, 32'h1);
    wait (txEmpty == 1'b1);
    @(negedge clk);
    chk(capCnt == 12 && capMosi == 16'h0456, "R12 resumed with kept entry",
        {8'(capCnt), capMosi}, {8'd12, 16'h0456});
    chk(csSeen == 4'b0110 && csN == 4'hF, "R8 decode resume", {csSeen, csN}, {4'b0110, 4'hF});
    @(negedge clk); rdAck = 1; @(negedge clk); rdAck = 0;
  endtask

  task automatic t_div;
    time t0, t1;
    wr(3'd1, 32'h0000_03E0);
    prep(8, 16'h0099);
    wr(3'd2, vw(0, 4'h0, 16'h0066));
    @(posedge sclk); t0 = $time;
    @(posedge sclk); t1 = $time;
    chk((t1 - t0) == 60, "R10 period", 32'(t1 - t0), 60);
    wait (txEmpty == 1'b1);
    @(negedge clk);
    chk(!sclk && capMosi == 16'h0066, "R10 idle low", {sclk, capMosi}, {1'b0, 16'h0066});
    @(negedge clk); rdAck = 1; @(negedge clk); rdAck = 0;
  endtask

  task automatic t_collision;
    wr(3'd1, 32'h0000_00E0);
    prep(8, 16'h00B4);
    rdAck = 1;
    wr(3'd2, vw(0, 4'h0, 16'h004B));
    wait (txEmpty == 1'b1);
    rdAck = 0;
    @(negedge clk);
    chk(rdrf && rxData == 16'h00B4, "R13 set wins", {rdrf, rxData}, {1'b1, 16'h00B4});
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    capMosi = 0; capCnt = 0; replyVec = 0; replyIdx = 0; csSeen = 4'hF;
    t_reset();
    wr(3'd0, 32'h1);
    wr(3'd4, 32'h00);
    wr(3'd5, 32'h08);
    wr(3'd6, 32'h14);
    wr(3'd7, 32'h02);
    t_fixed();
    t_tdre();
    t_variable();
    t_keep();
    t_nodecode();
    t_decode_disable();
    t_div();
    t_collision();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule